// File: doc/BRIEF.md
# Transmit Clock Loss Guard

This block watches the transmit input clock from a free-running reference clock and decides whether that clock is still alive. The monitored clock goes through a synchronizer chain into the reference domain. Each transition it carries, rising or falling, restarts an idle timer. When the timer runs a full programmed window with no transition, the block declares loss. It raises a live loss flag and sets a sticky status flag. The sticky flag holds until the host clears it.

A failover enable decides what loss does beyond reporting. With failover off, the block only reports. With failover on, the block drives the select line of an external glitch-free clock multiplexer to pick the receive clock. It also replaces the transmit data word with an all-ones alarm pattern for as long as the override lasts. The block returns to normal only after a programmed number of transitions arrive with no idle gap longer than the window. This hysteresis keeps a flickering clock from toggling the multiplexer.

The controller is a three-state machine:
- `S_PRESENT`: the clock is alive.
- `S_LOST`: loss is declared and no transition has been seen.
- `S_REGAIN`: transitions are being counted towards recovery.

The transitions are:
- PRESENT→LOST when the window expires.
- LOST→REGAIN on the first transition.
- REGAIN→PRESENT when the transition count reaches its target.
- REGAIN→LOST when the window expires again before the target is reached.

Top module: `tx_clk_loss_guard`

## Requirements
- R1: After reset, `loss_live`, `loss_sticky` and `clk_sel` are 0, and `tx_data_out` equals `tx_data_in`.
- R2: While the monitored clock transitions more often than once per `TIMEOUT_CYC` reference cycles, `loss_live` stays 0. Once transitions stop, `loss_live` rises no sooner than `TIMEOUT_CYC` cycles after the last transition and no later than `TIMEOUT_CYC` + 6 cycles after it. The extra cycles cover synchronizer latency.
- R3: `loss_sticky` is set one cycle after `loss_live` is 1, whatever the value of `failover_en`.
- R4: `loss_sticky` stays set until a one-cycle `loss_clr` pulse arrives while `loss_live` is 0. A `loss_clr` pulse while `loss_live` is 1 leaves it set.
- R5: While `loss_live` is 1 and `failover_en` is 0, `clk_sel` is 0 and `tx_data_out` equals `tx_data_in`.
- R6: While `loss_live` is 1 and `failover_en` is 1, `clk_sel` is 1 and `tx_data_out` is all ones. A value of 1 on `clk_sel` selects the receive clock. Both outputs follow `failover_en` in the same cycle.
- R7: After loss, `loss_live` returns to 0 only once `REGAIN_EDGES` transitions have been seen, both directions counting, with no gap of `TIMEOUT_CYC` cycles between them. Fewer transitions leave it at 1.
- R8: If the window expires during regain, the partial count is discarded, so a later recovery needs the full `REGAIN_EDGES` transitions again.
- R9: After recovery, `clk_sel` is 0 and `tx_data_out` equals `tx_data_in` regardless of `failover_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_clk | input | 1 | Monitored transmit input clock, asynchronous |
| failover_en | input | 1 | 1 = switch to receive clock and send alarm on loss |
| loss_clr | input | 1 | Host clear pulse for the sticky status |
| tx_data_in | input | DATA_W | Transmit data word |
| loss_live | output | 1 | Current loss condition |
| loss_sticky | output | 1 | Latched loss status |
| clk_sel | output | 1 | Clock multiplexer select, 1 = receive clock |
| tx_data_out | output | DATA_W | Transmit data after alarm override |

## Verification
The bench builds the block with its defaults: `TIMEOUT_CYC` 16, `REGAIN_EDGES` 4, `DATA_W` 8 and two synchronizer stages. The 16-cycle window lets loss be provoked and cleared within a few tens of reference cycles. A target of four transitions leaves room for a three-transition burst that must not release the override, followed by an expiry that must discard the partial count.

// File: rtl/tclg_pkg.sv
package tclg_pkg;

    typedef enum logic [1:0] {
        S_PRESENT = 2'd0,
        S_LOST    = 2'd1,
        S_REGAIN  = 2'd2
    } guard_state_e;

endpackage

// File: rtl/tclg_sync_edge.sv
// Brings the monitored clock into the reference domain and flags each transition.
module tclg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_seen
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_ref or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk_ref or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign edge_seen = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/tclg_idle_timer.sv
// Counts reference cycles since the last transition; saturates at the window.
module tclg_idle_timer #(
    parameter int WINDOW = 16
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic edge_seen,
    output logic expired
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] idle_q;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)                        idle_q <= '0;
        else if (edge_seen)                idle_q <= '0;
        else if (idle_q != CW'(WINDOW))    idle_q <= idle_q + 1'b1;
    end

    assign expired = (idle_q == CW'(WINDOW));

    assert_no_overflow_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        idle_q <= CW'(WINDOW));

endmodule

// File: rtl/tclg_edge_tally.sv
// Counts transitions towards recovery; saturates at the target.
module tclg_edge_tally #(
    parameter int TARGET = 4
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic clear,
    input  logic edge_seen,
    output logic done
);
    localparam int TW = $clog2(TARGET + 1);

    logic [TW-1:0] tally_q;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)                               tally_q <= '0;
        else if (clear)                           tally_q <= '0;
        else if (edge_seen && tally_q != TW'(TARGET)) tally_q <= tally_q + 1'b1;
    end

    assign done = (tally_q == TW'(TARGET));

    assert_tally_bound_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        tally_q <= TW'(TARGET));

endmodule

// File: rtl/tx_clk_loss_guard.sv
module tx_clk_loss_guard
    import tclg_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int TIMEOUT_CYC  = 16,
    parameter int REGAIN_EDGES = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              mon_clk,
    input  logic              failover_en,
    input  logic              loss_clr,
    input  logic [DATA_W-1:0] tx_data_in,
    output logic              loss_live,
    output logic              loss_sticky,
    output logic              clk_sel,
    output logic [DATA_W-1:0] tx_data_out
);
    localparam logic [DATA_W-1:0] ALARM_WORD = '1;

    guard_state_e state_q, state_d;
    logic edge_seen, expired, tally_done, tally_clear;

    tclg_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .async_in  (mon_clk),
        .edge_seen (edge_seen)
    );

    tclg_idle_timer #(.WINDOW(TIMEOUT_CYC)) i_timer (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .edge_seen (edge_seen),
        .expired   (expired)
    );

    assign tally_clear = (state_q == S_PRESENT) || (state_q == S_REGAIN && expired && !tally_done);

    tclg_edge_tally #(.TARGET(REGAIN_EDGES)) i_tally (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .clear     (tally_clear),
        .edge_seen (edge_seen),
        .done      (tally_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_PRESENT: if (expired)    state_d = S_LOST;
            S_LOST:    if (edge_seen)  state_d = S_REGAIN;
            S_REGAIN: begin
                if (tally_done)        state_d = S_PRESENT;
                else if (expired)      state_d = S_LOST;
            end
            default:                   state_d = S_LOST;
        endcase
    end

    // State register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= S_PRESENT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        loss_live   = (state_q != S_PRESENT);
        clk_sel     = loss_live && failover_en;
        tx_data_out = clk_sel ? ALARM_WORD : tx_data_in;
    end

    // Sticky status, set dominates clear
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)         loss_sticky <= 1'b0;
        else if (loss_live) loss_sticky <= 1'b1;
        else if (loss_clr)  loss_sticky <= 1'b0;
    end

    assert_loss_from_window_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(loss_live) |-> $past(expired));

    assert_sticky_follows_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        loss_live |=> loss_sticky);

    assert_clear_blocked_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (loss_live && loss_sticky) |=> loss_sticky);

    assert_release_needs_count_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(loss_live) |-> $past(tally_done));

endmodule

// File: tb/test_tx_clk_loss_guard.sv
module test_tx_clk_loss_guard;
    localparam int DW = 8;

    logic clk_ref = 1'b0;
    logic rst_n = 1'b0;
    logic mon_clk = 1'b0;
    logic failover_en = 1'b0;
    logic loss_clr = 1'b0;
    logic [DW-1:0] tx_data_in = '0;
    logic loss_live, loss_sticky, clk_sel;
    logic [DW-1:0] tx_data_out;

    int checks = 0;
    int errors = 0;
    bit run = 1'b0;
    int budget = 0;
    bit done = 1'b0;

    tx_clk_loss_guard #(.DATA_W(DW), .TIMEOUT_CYC(16), .REGAIN_EDGES(4), .SYNC_STAGES(2)) i_tx_clk_loss_guard (
        .clk_ref(clk_ref), .rst_n(rst_n), .mon_clk(mon_clk), .failover_en(failover_en),
        .loss_clr(loss_clr), .tx_data_in(tx_data_in), .loss_live(loss_live),
        .loss_sticky(loss_sticky), .clk_sel(clk_sel), .tx_data_out(tx_data_out)
    );

    initial forever #2 clk_ref = ~clk_ref;

    // Monitored clock: free running when run=1, else emits 'budget' transitions
    initial forever begin
        #8;
        if (run) mon_clk = ~mon_clk;
        else if (budget > 0) begin
            mon_clk = ~mon_clk;
            budget = budget - 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_ref);
    endtask

    task automatic set_run(input bit r);
        if (r != run) begin
            run = r;
            cycles(r ? 30 : 40);
        end
    endtask

    task automatic give_edges(input int n);
        budget = n;
        wait (budget == 0);
        cycles(1);
    endtask

    // {run, failover_en, data, expected clk_sel, expected data out}
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h3C, 1'b0, 8'h3C},   // R9 path clean
        {1'b1, 1'b1, 8'hA5, 1'b0, 8'hA5},   // R9 failover armed, clock fine
        {1'b0, 1'b0, 8'h5A, 1'b0, 8'h5A},   // R5
        {1'b0, 1'b1, 8'h12, 1'b1, 8'hFF},   // R6
        {1'b0, 1'b0, 8'h81, 1'b0, 8'h81},   // R5 failover dropped mid-loss
        {1'b0, 1'b1, 8'h00, 1'b1, 8'hFF},   // R6
        {1'b1, 1'b1, 8'h77, 1'b0, 8'h77},   // R9 after recovery
        {1'b1, 1'b0, 8'hE0, 1'b0, 8'hE0}    // R9
    };

    initial begin
        cycles(3);
        tx_data_in = 8'h6B;
        cycles(1);
        check("R1 live", {31'd0, loss_live}, 32'd0);
        check("R1 sticky", {31'd0, loss_sticky}, 32'd0);
        check("R1 sel", {31'd0, clk_sel}, 32'd0);
        check("R1 data", {24'd0, tx_data_out}, 32'h6B);
        rst_n = 1'b1;
        run = 1'b1;
        cycles(60);
        check("R2 no loss while toggling", {31'd0, loss_live}, 32'd0);

        // R2 window timing, failover off (R3 regardless of failover)
        failover_en = 1'b0;
        run = 1'b0;
        cycles(12);
        check("R2 not before window", {31'd0, loss_live}, 32'd0);
        cycles(12);
        check("R2 declared after window", {31'd0, loss_live}, 32'd1);
        cycles(1);
        check("R3 sticky set failover off", {31'd0, loss_sticky}, 32'd1);

        // R4 clear while lost has no effect
        loss_clr = 1'b1; cycles(1); loss_clr = 1'b0; cycles(1);
        check("R4 clear ignored while lost", {31'd0, loss_sticky}, 32'd1);

        // R7 fewer edges keep loss
        give_edges(3);
        cycles(3);
        check("R7 three edges not enough", {31'd0, loss_live}, 32'd1);
        give_edges(1);
        cycles(6);
        check("R7 fourth edge releases", {31'd0, loss_live}, 32'd0);
        check("R4 sticky holds after recovery", {31'd0, loss_sticky}, 32'd1);
        loss_clr = 1'b1; cycles(1); loss_clr = 1'b0; cycles(1);
        check("R4 clear when not lost", {31'd0, loss_sticky}, 32'd0);

        // R8 partial count discarded on expiry
        cycles(30);
        check("R2 loss again", {31'd0, loss_live}, 32'd1);
        give_edges(2);
        cycles(40);
        check("R8 still lost after partial burst", {31'd0, loss_live}, 32'd1);
        give_edges(3);
        cycles(3);
        check("R8 count restarted", {31'd0, loss_live}, 32'd1);
        give_edges(1);
        cycles(6);
        check("R8 full count releases", {31'd0, loss_live}, 32'd0);

        // R3 with failover on
        loss_clr = 1'b1; cycles(1); loss_clr = 1'b0;
        failover_en = 1'b1;
        run = 1'b1; cycles(20);
        run = 1'b0; cycles(40);
        check("R3 sticky set failover on", {31'd0, loss_sticky}, 32'd1);
        check("R6 sel during loss", {31'd0, clk_sel}, 32'd1);
        failover_en = 1'b0;
        set_run(1'b1);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            set_run(VEC[v][18]);
            failover_en = VEC[v][17];
            tx_data_in = VEC[v][16:9];
            cycles(1);
            check($sformatf("R5/R6/R9 vec%0d live", v), {31'd0, loss_live}, {31'd0, ~VEC[v][18]});
            check($sformatf("R5/R6/R9 vec%0d sel", v), {31'd0, clk_sel}, {31'd0, VEC[v][8]});
            check($sformatf("R5/R6/R9 vec%0d data", v), {24'd0, tx_data_out}, {24'd0, VEC[v][7:0]});
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk_ref);
                checks++; errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule